// File: doc/BRIEF.md
# Timer Divider Factorization Search Engine

This block takes a target divide ratio, the timer input clock divided by the wanted update rate, and looks for two divider settings, a prescaler value and a reload value, whose divisors multiply to that ratio. The prescaler setting is PSC and the reload setting is ARR. The prescaler divisor is PSC+1 and the reload divisor is ARR+1, and each setting is PW bits wide (16 by default). The ratio is 2·PW bits wide. A ratio larger than one register can hold is still handled, because the work is split across both dividers.

One start pulse begins a search. The engine then tries prescaler divisors d = 1, 2, … 2^PW in ascending order, one per clock. For each d it forms the nearest reload divisor and the size of the product error. It keeps the best pair seen so far and stops at the first exact factorization. If no exact factorization exists, it reports the pair with the smallest error. A one-cycle done pulse marks the result. The outputs then hold until the next accepted start. Converting a period or frequency into the integer ratio is left to the caller.

Top module: `fact_search`

## Requirements
- R1: A start pulse seen while idle latches `ratio`. For a non-zero ratio, `busy` is 1 from the next cycle until the cycle in which `done` is 1, and `busy` is 0 in that cycle.
- R2: For 1 ≤ ratio ≤ 2^PW, the result is psc=0, arr=ratio−1, err=0 and exact=1. `done` is 1 in the second cycle after the start cycle.
- R3: Divisors are tried in ascending order, one per cycle, and the search ends at the first d that gives zero error. For ratio 193,200,000 this gives psc=2999, arr=64399, err=0, exact=1.
- R4: For a divisor d, the reload divisor q is R/d rounded to nearest, with halves rounded up. q is clamped to the range 1 to 2^PW, and the error is |R − d·q|.
- R5: When no exact pair exists, the result is the pair with the smallest error, with ties going to the smallest d, and exact=0. Ratio 65537 gives psc=0, arr=65535, err=1. Ratio 0xFFFFFFFF gives psc=65535, arr=65535, err=1.
- R6: `done` is high for exactly one cycle. After it, `psc`, `arr`, `err`, `exact` and `invalid` stay unchanged until the next accepted start.
- R7: A start pulse while `busy` is 1 is ignored, and the running search finishes with the ratio first latched.
- R8: A ratio of 0 gives invalid=1, exact=0, err all ones and psc=arr=0, with `done` in the cycle right after the start cycle and no busy phase.
- R9: After reset, busy, done, exact and invalid are 0, psc and arr are 0, and err is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search, accepted only while idle |
| ratio | input | 2·PW | Target divide ratio R |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| psc | output | PW | Prescaler setting (divisor − 1) |
| arr | output | PW | Reload setting (divisor − 1) |
| err | output | 2·PW | Absolute product error, all ones when invalid |
| exact | output | 1 | Result has zero error |
| invalid | output | 1 | Ratio was zero |

## Verification
The assertions check a set of per-cycle properties. `done` is a single-cycle pulse and never coincides with `busy`. The outputs are held while idle. A zero ratio completes in the following cycle with a saturated error. Exact results carry zero error. The best error never rises during a search. Whether the chosen pair is actually the best one, including the rounding, clamping and tie-breaking rules, depends on the whole sweep, so only the bench's scenarios can show it. The bench compares directed and random ratios against a reference search. Those scenarios also cover the ignored mid-search start and the early stop on the first exact factor.

// File: rtl/fs_pkg.sv
// Shared types for the factorization search engine.
// Assumes: nothing beyond a two-state controller.
package fs_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fs_state_t;
endpackage

// File: rtl/fs_cand_eval.sv
// Evaluates one prescaler candidate: nearest reload divisor, clamped, and
// the absolute product error against the ratio.
// Assumes: idx holds divisor-1 so divisor spans 1..2^PW; RW = 2*PW.
module fs_cand_eval #(
    parameter int PW = 16,
    parameter int RW = 2 * PW
) (
    input  logic [RW-1:0] ratio,
    input  logic [PW-1:0] idx,
    output logic [PW-1:0] arr,
    output logic [RW-1:0] err
);
    localparam int NW = RW + 1;
    localparam int XW = 2 * PW + 2;
    localparam logic [NW-1:0] LIM = NW'(1) << PW;

    logic [PW:0]   div;
    logic [NW-1:0] num;
    logic [NW-1:0] qraw;
    logic [PW:0]   q;
    logic [XW-1:0] prod;
    logic [XW-1:0] rext;
    logic [XW-1:0] diff;

    // Rounded quotient, clamped reload setting and error magnitude.
    always_comb begin
        div  = {1'b0, idx} + 1'b1;
        num  = {1'b0, ratio} + NW'(div >> 1);
        qraw = num / NW'(div);
        if (qraw == '0)
            arr = '0;
        else if (qraw > LIM)
            arr = '1;
        else
            arr = qraw[PW-1:0] - 1'b1;
        q    = {1'b0, arr} + 1'b1;
        prod = XW'(div) * XW'(q);
        rext = XW'(ratio);
        diff = (rext >= prod) ? (rext - prod) : (prod - rext);
        err  = (|diff[XW-1:RW]) ? '1 : diff[RW-1:0];
    end
endmodule

// File: rtl/fs_best_keep.sv
// Holds the best candidate seen in the current search.
// Assumes: candidates arrive in ascending divisor order, so a strict
// comparison keeps the smallest divisor among equal errors.
module fs_best_keep #(
    parameter int PW = 16,
    parameter int RW = 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [PW-1:0] c_psc,
    input  logic [PW-1:0] c_arr,
    input  logic [RW-1:0] c_err,
    output logic [PW-1:0] b_psc,
    output logic [PW-1:0] b_arr,
    output logic [RW-1:0] b_err
);
    // Reset or clear to the empty result, else take a strictly better candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            b_psc <= '0;
            b_arr <= '0;
            b_err <= '1;
        end else if (load && (c_err < b_err)) begin
            b_psc <= c_psc;
            b_arr <= c_arr;
            b_err <= c_err;
        end
    end

    // R5
    best_nonincreasing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (b_err <= $past(b_err)));
endmodule

// File: rtl/fact_search.sv
// Top of the factorization search engine. A start while idle latches the
// ratio and sweeps prescaler divisors 1..2^PW, one per cycle, stopping at
// the first exact pair; done pulses once with the held result.
// Assumes: ratio width is 2*PW; a ratio of 0 is reported as invalid.
module fact_search
    import fs_pkg::*;
#(
    parameter int PW = 16,
    localparam int RW = 2 * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] ratio,
    output logic          busy,
    output logic          done,
    output logic [PW-1:0] psc,
    output logic [PW-1:0] arr,
    output logic [RW-1:0] err,
    output logic          exact,
    output logic          invalid
);
    localparam logic [PW-1:0] LAST = '1;

    fs_state_t     state;
    logic [RW-1:0] ratio_q;
    logic [PW-1:0] idx_q;
    logic          done_q;
    logic          exact_q;
    logic          invalid_q;
    logic [PW-1:0] c_arr;
    logic [RW-1:0] c_err;
    logic          accept;
    logic          running;

    assign accept  = (state == FS_IDLE) && start;
    assign running = (state == FS_RUN);

    fs_cand_eval #(.PW(PW), .RW(RW)) u_eval (
        .ratio (ratio_q),
        .idx   (idx_q),
        .arr   (c_arr),
        .err   (c_err)
    );

    fs_best_keep #(.PW(PW), .RW(RW)) u_best (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .load  (running),
        .c_psc (idx_q),
        .c_arr (c_arr),
        .c_err (c_err),
        .b_psc (psc),
        .b_arr (arr),
        .b_err (err)
    );

    // Search controller: accept, step the divisor, finish on exact or last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_IDLE;
            ratio_q   <= '0;
            idx_q     <= '0;
            done_q    <= 1'b0;
            exact_q   <= 1'b0;
            invalid_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                FS_IDLE: begin
                    if (start) begin
                        ratio_q <= ratio;
                        idx_q   <= '0;
                        exact_q <= 1'b0;
                        if (ratio == '0) begin
                            invalid_q <= 1'b1;
                            done_q    <= 1'b1;
                        end else begin
                            invalid_q <= 1'b0;
                            state     <= FS_RUN;
                        end
                    end
                end
                default: begin
                    if ((c_err == '0) || (idx_q == LAST)) begin
                        state   <= FS_IDLE;
                        done_q  <= 1'b1;
                        exact_q <= (c_err == '0);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = running;
    assign done    = done_q;
    assign exact   = exact_q;
    assign invalid = invalid_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({psc, arr, err, exact, invalid}));

    // R8
    zero_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (ratio == '0)) |=> (done && invalid && !exact && (&err)));

    // R3
    exact_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exact) |-> (err == '0));

    // R7
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));
endmodule

// File: tb/sim_fact_search.sv
module sim_fact_search;
    localparam int  PW     = 16;
    localparam int  RW     = 2 * PW;
    localparam time TCLK   = 10ns;
    localparam int  WD_MAX = 195000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] ratio = '0;
    logic          busy, done, exact, invalid;
    logic [PW-1:0] psc, arr;
    logic [RW-1:0] err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    fact_search #(.PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio),
        .busy(busy), .done(done), .psc(psc), .arr(arr), .err(err),
        .exact(exact), .invalid(invalid)
    );

    always #(TCLK / 2) clk = ~clk;

    // Watchdog: an expired run counts as one failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_MAX) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WD_MAX);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Reference search built from the requirement text.
    function automatic void ref_search(input longint r, output longint rp, output longint ra,
                                       output longint re, output bit rx);
        longint lim = longint'(1) << PW;
        longint best = (longint'(1) << RW) - 1;
        rp = 0; ra = 0; re = best; rx = 0;
        for (longint d = 1; d <= lim; d++) begin
            longint q = (r + d / 2) / d;
            longint e;
            if (q < 1) q = 1;
            if (q > lim) q = lim;
            e = (r >= d * q) ? r - d * q : d * q - r;
            if (e < best) begin
                best = e; rp = d - 1; ra = q - 1; re = e;
            end
            if (e == 0) begin
                rx = 1;
                break;
            end
        end
    endfunction

    // Runs a search and returns the negedge count from start to done.
    task automatic run(input logic [RW-1:0] r, output int lat, output bit busy_seen);
        @(negedge clk);
        start = 1'b1; ratio = r;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy_seen = busy;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic compare(input logic [RW-1:0] r, input string tag);
        longint rp, ra, re;
        bit rx;
        ref_search(longint'(r), rp, ra, re, rx);
        chk(psc == rp, {tag, " psc"}, psc, rp);
        chk(arr == ra, {tag, " arr"}, arr, ra);
        chk(err == re, {tag, " err"}, err, re);
        chk(exact == rx, {tag, " exact"}, exact, rx);
    endtask

    initial begin
        int lat;
        bit bs;
        logic [PW-1:0] hp, ha;
        logic [RW-1:0] he;
        void'($urandom(32'd4083));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !exact && !invalid, "R9 flags", {busy, done, exact, invalid}, 0);
        chk(psc == 0 && arr == 0, "R9 psc/arr", {psc, arr}, 0);
        chk(&err, "R9 err", err, 64'hFFFFFFFF);

        // R2 trivial ratio and latency
        run(32'd7, lat, bs);
        chk(lat == 2, "R2 latency", lat, 2);
        chk(bs, "R1 busy after start", bs, 1);
        chk(!busy, "R1 busy low at done", busy, 0);
        chk(psc == 0 && arr == 6 && err == 0 && exact, "R2 ratio 7", arr, 6);
        run(32'd65536, lat, bs);
        chk(psc == 0 && arr == 65535 && exact, "R2 ratio 65536", arr, 65535);
        run(32'd1, lat, bs);
        chk(psc == 0 && arr == 0 && exact, "R2 ratio 1", arr, 0);

        // R6 pulse and hold
        @(negedge clk);
        chk(!done, "R6 done pulse", done, 0);
        hp = psc; ha = arr; he = err;
        repeat (5) @(negedge clk);
        chk(psc == hp && arr == ha && err == he, "R6 hold", psc, hp);

        // R8 zero ratio
        run(32'd0, lat, bs);
        chk(lat == 1, "R8 latency", lat, 1);
        chk(!bs, "R8 no busy", bs, 0);
        chk(invalid && !exact && (&err) && psc == 0 && arr == 0, "R8 result", err, 64'hFFFFFFFF);

        // R3 early stop on first exact factor, R7 ignored start mid-search
        @(negedge clk);
        start = 1'b1; ratio = 32'd193200000;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy, "R7 busy mid-search", busy, 1);
        start = 1'b1; ratio = 32'd5;
        @(negedge clk);
        start = 1'b0;
        lat = 12;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        chk(psc == 2999 && arr == 64399 && err == 0 && exact, "R3 193200000", psc, 2999);
        chk(lat == 3001, "R3 one divisor per cycle", lat, 3001);
        compare(32'd193200000, "R7 ignored start");

        // R4 rounding and clamps through random factorable ratios
        for (int i = 0; i < 20; i++) begin
            logic [RW-1:0] a = RW'($urandom_range(300, 1));
            logic [RW-1:0] b = RW'($urandom_range(65536, 1));
            run(a * b, lat, bs);
            compare(a * b, "R4 random product");
        end
        for (int i = 0; i < 6; i++) begin
            logic [RW-1:0] t = RW'($urandom_range(65536, 1));
            run(t, lat, bs);
            compare(t, "R2 random trivial");
        end

        // R5 no exact pair: smallest error, ties to smallest divisor
        run(32'd65537, lat, bs);
        chk(psc == 0 && arr == 65535 && err == 1 && !exact, "R5 ratio 65537", {psc, arr}, 65535);
        run(32'hFFFFFFFF, lat, bs);
        chk(psc == 65535 && arr == 65535 && err == 1 && !exact, "R5 ratio max", {psc, arr}, 32'hFFFFFFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule